// File: doc/BRIEF.md
# Teletext Request Window Generator

This block drives the teletext request strobe of a video encoder. It counts video lines from the field synchronisation pulse and asserts requests only on lines inside a programmable window. Each field parity has its own first-line and last-line register. The offsets added to those registers depend on the field rate: 60 Hz M-systems use different offsets from 50 Hz systems. A per-field line mask can then remove single lines from the window. The mask is indexed with 50 Hz line numbering, so the same mask bit names the same picture line in either system.

On an enabled line the block waits for a programmable horizontal start position. It then serves the data source in one of two ways. In the per-bit protocol it emits one single-tick pulse per teletext bit: the pulses are spaced by a programmable bit period, and a programmable number of them is issued on each line. In the continuous protocol it holds the request high for one window. The length of that window comes from the teletext standard selected. All timing advances only on pixel ticks (`pixEn` high). Configuration is written into a pending copy, and that copy becomes active at the next field sync. A window therefore never changes part-way through a field.

Top module: `ttx_req_window`

## Requirements
- R1: A pixel tick with `fieldSync` high sets the line number to 0. The same tick captures the field parity from `fieldOdd` (1 selects the odd-field registers, 0 the even-field registers). Each later pixel tick with `lineStrobe` high adds one to the line number. Line 0 never carries a request.
- R2: With `cfgSysM`=0 (50 Hz), a line L of the current field is enabled when first+1 <= L <= last. Here first and last are that parity's start and end registers, unchanged.
- R3: With `cfgSysM`=1 (60 Hz M-system), a line L is enabled when first+4 <= L <= last+3.
- R4: After reset, both parities' start/end registers hold 0x04/0x16 when `strapNtsc`=0 and 0x05/0x10 when `strapNtsc`=1. The field-rate bit equals `strapNtsc`. The protocol and standard bits and both masks are 0. Horizontal start, bit period and bit count take their parameter defaults. `ttxReq` is 0.
- R5: Bit i of the current parity's mask disables the line whose 50 Hz number equals MASK_BASE+i. The 50 Hz number is L when `cfgSysM`=0 and L-3 when `cfgSysM`=1. The mask can only remove lines that the window enables.
- R6: With `cfgProtoOld`=0, take the tick index m of a line, with the line-start tick as m=0, and let h be the horizontal start. On an enabled line `ttxReq` is high for exactly the ticks m = h+1+k*d, for k = 0 .. bitCount-1. Here d is the bit period, and a period below 2 is treated as 2. With bitCount 0 the line carries no pulse.
- R7: With `cfgProtoOld`=1, `ttxReq` on an enabled line is high for every tick from m = h+1 up to m = h+W, one continuous window of W ticks.
- R8: W is WIN_EURO when `cfgSysM`=0. It is WIN_NABTS when `cfgSysM`=1 and `cfgStd60`=0, and WIN_WST when `cfgSysM`=1 and `cfgStd60`=1.
- R9: A cycle with `cfgLoad` high (independent of `pixEn`) copies all `cfg*` inputs into the pending set. The pending set becomes active only at the next field-sync tick.
- R10: In a cycle with `pixEn` low nothing changes: no line or pixel count, no request state and no output. `lineStrobe` and `fieldSync` are ignored in such a cycle.
- R11: A line-start tick (`lineStrobe` or `fieldSync` with `pixEn`) drives `ttxReq` low. It cuts short any pulse train or window still running from the previous line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| strapNtsc | input | 1 | Strap selecting the reset defaults (1 = 60 Hz set) |
| pixEn | input | 1 | Pixel tick qualifier |
| lineStrobe | input | 1 | Start of a new line |
| fieldSync | input | 1 | First field sync pulse, starts line 0 |
| fieldOdd | input | 1 | Field parity, sampled on the field-sync tick |
| cfgLoad | input | 1 | Capture the cfg inputs into the pending set |
| cfgSysM | input | 1 | 1 = 60 Hz M-system offsets |
| cfgProtoOld | input | 1 | 1 = continuous window, 0 = per-bit pulses |
| cfgStd60 | input | 1 | Standard select for the 60 Hz window length |
| cfgOddFirst | input | 8 | Odd-field start register |
| cfgOddLast | input | 8 | Odd-field end register |
| cfgEvenFirst | input | 8 | Even-field start register |
| cfgEvenLast | input | 8 | Even-field end register |
| cfgMaskOdd | input | 16 | Odd-field line disable mask |
| cfgMaskEven | input | 16 | Even-field line disable mask |
| cfgHStart | input | 11 | Horizontal start position in ticks |
| cfgBitDiv | input | 6 | Bit period in ticks |
| cfgBitCount | input | 9 | Pulses per line |
| ttxReq | output | 1 | Teletext request |

## Verification
Some properties are checked on every cycle. A request is never seen on a line whose enable flag is clear. A line start always leaves the request low. A per-bit pulse never lasts past one tick. A cycle without a pixel tick leaves the output unchanged. The active configuration moves only on a field-sync tick, and that tick always restarts the line count. The exact placement of the window edges under both offset rules, the mask indexing in 50 Hz numbering, the pulse positions and counts, the three window lengths and the deferred effect of a mid-field write depend on programmed values. Only the bench scenarios, compared tick by tick against a behavioural model, show these.

// File: rtl/ttx_req_pkg.sv
package ttx_req_pkg;

  localparam int REG_W  = 8;
  localparam int MASK_W = 16;
  localparam int PIX_W  = 11;
  localparam int DIV_W  = 6;
  localparam int CNT_W  = 9;

  localparam logic [REG_W-1:0] PAL_FIRST  = 8'h04;
  localparam logic [REG_W-1:0] PAL_LAST   = 8'h16;
  localparam logic [REG_W-1:0] NTSC_FIRST = 8'h05;
  localparam logic [REG_W-1:0] NTSC_LAST  = 8'h10;

  typedef struct packed {
    logic              sysM;
    logic              protoOld;
    logic              std60;
    logic [REG_W-1:0]  oddFirst;
    logic [REG_W-1:0]  oddLast;
    logic [REG_W-1:0]  evenFirst;
    logic [REG_W-1:0]  evenLast;
    logic [MASK_W-1:0] maskOdd;
    logic [MASK_W-1:0] maskEven;
    logic [PIX_W-1:0]  hStart;
    logic [DIV_W-1:0]  bitDiv;
    logic [CNT_W-1:0]  bitCount;
  } ttxCfg_t;

  typedef struct packed {
    logic slotLoadBit;
    logic slotLoadWin;
    logic slotDec;
    logic leftLoad;
    logic leftDec;
  } ttxStrobe_t;

  typedef struct packed {
    logic lineOk;
    logic atHStart;
    logic slotZero;
    logic leftZero;
    logic protoOld;
    logic noBits;
  } ttxStatus_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } ctlState_t;

endpackage

// File: rtl/ttx_req_dp.sv
module ttx_req_dp
  import ttx_req_pkg::*;
#(
  parameter int               LINE_W     = 10,
  parameter int               MASK_BASE  = 7,
  parameter logic [PIX_W-1:0] WIN_EURO   = 11'd360,
  parameter logic [PIX_W-1:0] WIN_NABTS  = 11'd288,
  parameter logic [PIX_W-1:0] WIN_WST    = 11'd296,
  parameter logic [PIX_W-1:0] DEF_HSTART = 11'd48,
  parameter logic [DIV_W-1:0] DEF_DIV    = 6'd4,
  parameter logic [CNT_W-1:0] DEF_CNT    = 9'd45
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       strapNtsc,
  input  logic       pixEn,
  input  logic       lineStart,
  input  logic       fieldSync,
  input  logic       fieldOdd,
  input  logic       cfgLoad,
  input  ttxCfg_t    cfgIn,
  input  ttxStrobe_t strobe,
  output ttxStatus_t status
);

  localparam int MIDX_W = $clog2(MASK_W);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;
  localparam logic [PIX_W-1:0]  PIX_MAX  = '1;

  ttxCfg_t defCfg, pendCfg, actCfg;

  logic [LINE_W-1:0] lineCnt, nextLine, firstLine, lastLine, palLine, maskOff;
  logic [REG_W-1:0]  selFirst, selLast;
  logic [MASK_W-1:0] selMask;
  logic              oddField, lineOk, inWin, palValid, inMask, masked, okNext;
  logic [PIX_W-1:0]  pixCnt, slotCnt, bitLoad, winLoad;
  logic [DIV_W-1:0]  bitDivEff;
  logic [CNT_W-1:0]  leftCnt;

  // strap-selected reset values
  always_comb begin
    defCfg           = '0;
    defCfg.sysM      = strapNtsc;
    defCfg.oddFirst  = strapNtsc ? NTSC_FIRST : PAL_FIRST;
    defCfg.evenFirst = strapNtsc ? NTSC_FIRST : PAL_FIRST;
    defCfg.oddLast   = strapNtsc ? NTSC_LAST  : PAL_LAST;
    defCfg.evenLast  = strapNtsc ? NTSC_LAST  : PAL_LAST;
    defCfg.hStart    = DEF_HSTART;
    defCfg.bitDiv    = DEF_DIV;
    defCfg.bitCount  = DEF_CNT;
  end

  // pending copy written any time, active copy only at the field boundary
  always_ff @(posedge clk) begin
    if (!rstN)        pendCfg <= defCfg;
    else if (cfgLoad) pendCfg <= cfgIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     actCfg <= defCfg;
    else if (pixEn && fieldSync)   actCfg <= pendCfg;
  end

  // window test for the line about to start
  always_comb begin
    nextLine  = (lineCnt == LINE_MAX) ? lineCnt : lineCnt + 1'b1;
    selFirst  = oddField ? actCfg.oddFirst : actCfg.evenFirst;
    selLast   = oddField ? actCfg.oddLast  : actCfg.evenLast;
    selMask   = oddField ? actCfg.maskOdd  : actCfg.maskEven;
    firstLine = LINE_W'(selFirst) + (actCfg.sysM ? LINE_W'(4) : LINE_W'(1));
    lastLine  = LINE_W'(selLast)  + (actCfg.sysM ? LINE_W'(3) : LINE_W'(0));
    inWin     = (nextLine >= firstLine) && (nextLine <= lastLine);
    palValid  = !actCfg.sysM || (nextLine >= LINE_W'(3));
    palLine   = actCfg.sysM ? nextLine - LINE_W'(3) : nextLine;
    maskOff   = palLine - LINE_W'(MASK_BASE);
    inMask    = palValid && (palLine >= LINE_W'(MASK_BASE)) && (maskOff < LINE_W'(MASK_W));
    masked    = inMask && selMask[maskOff[MIDX_W-1:0]];
    okNext    = inWin && !masked;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt  <= '0;
      oddField <= 1'b0;
      lineOk   <= 1'b0;
    end else if (lineStart) begin
      if (fieldSync) begin
        lineCnt  <= '0;
        oddField <= fieldOdd;
        lineOk   <= 1'b0;
      end else begin
        lineCnt  <= nextLine;
        lineOk   <= okNext;
      end
    end
  end

  // horizontal position within the line
  always_ff @(posedge clk) begin
    if (!rstN)                           pixCnt <= '0;
    else if (lineStart)                  pixCnt <= '0;
    else if (pixEn && pixCnt != PIX_MAX) pixCnt <= pixCnt + 1'b1;
  end

  // slot and pulse counters loaded by the control strobes
  always_comb begin
    bitDivEff = (actCfg.bitDiv < DIV_W'(2)) ? DIV_W'(2) : actCfg.bitDiv;
    bitLoad   = PIX_W'(bitDivEff) - 1'b1;
    if (!actCfg.sysM)      winLoad = WIN_EURO - 1'b1;
    else if (actCfg.std60) winLoad = WIN_WST - 1'b1;
    else                   winLoad = WIN_NABTS - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) slotCnt <= '0;
    else if (pixEn) begin
      if (strobe.slotLoadBit)      slotCnt <= bitLoad;
      else if (strobe.slotLoadWin) slotCnt <= winLoad;
      else if (strobe.slotDec)     slotCnt <= slotCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) leftCnt <= '0;
    else if (pixEn) begin
      if (strobe.leftLoad)     leftCnt <= actCfg.bitCount - 1'b1;
      else if (strobe.leftDec) leftCnt <= leftCnt - 1'b1;
    end
  end

  assign status.lineOk   = lineOk;
  assign status.atHStart = (pixCnt == actCfg.hStart);
  assign status.slotZero = (slotCnt == '0);
  assign status.leftZero = (leftCnt == '0);
  assign status.protoOld = actCfg.protoOld;
  assign status.noBits   = (actCfg.bitCount == '0);

  AST_LINE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (pixEn && fieldSync) |=> (lineCnt == '0 && !lineOk)) else $error("line restart"); // R1

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(pixEn && fieldSync) |=> $stable(actCfg)) else $error("config moved mid-field"); // R9

endmodule

// File: rtl/ttx_req_ctl.sv
module ttx_req_ctl
  import ttx_req_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pixEn,
  input  logic       lineStart,
  input  ttxStatus_t status,
  output ttxStrobe_t strobe,
  output logic       ttxReq
);

  ctlState_t state, stateNext;
  logic      reqNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    reqNext   = ttxReq;
    if (pixEn) begin
      if (lineStart) begin
        stateNext = ST_WAIT;
        reqNext   = 1'b0;
      end else begin
        unique case (state)
          ST_WAIT: begin
            if (!status.lineOk) begin
              stateNext = ST_IDLE;
            end else if (status.atHStart) begin
              if (!status.protoOld && status.noBits) begin
                stateNext = ST_IDLE;
              end else begin
                stateNext = ST_RUN;
                reqNext   = 1'b1;
                if (status.protoOld) begin
                  strobe.slotLoadWin = 1'b1;
                end else begin
                  strobe.slotLoadBit = 1'b1;
                  strobe.leftLoad    = 1'b1;
                end
              end
            end
          end
          ST_RUN: begin
            if (status.protoOld) begin
              if (status.slotZero) begin
                stateNext = ST_IDLE;
                reqNext   = 1'b0;
              end else begin
                strobe.slotDec = 1'b1;
              end
            end else begin
              reqNext = 1'b0;
              if (status.slotZero) begin
                if (status.leftZero) begin
                  stateNext = ST_IDLE;
                end else begin
                  reqNext            = 1'b1;
                  strobe.slotLoadBit = 1'b1;
                  strobe.leftDec     = 1'b1;
                end
              end else begin
                strobe.slotDec = 1'b1;
              end
            end
          end
          default: begin
            stateNext = ST_IDLE;
            reqNext   = 1'b0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      ttxReq <= 1'b0;
    end else begin
      state  <= stateNext;
      ttxReq <= reqNext;
    end
  end

  AST_REQ_CUT: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> !ttxReq) else $error("request survived line start"); // R11

  AST_BIT_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (pixEn && ttxReq && !status.protoOld) |=> !ttxReq) else $error("bit pulse too long"); // R6

  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !pixEn |=> $stable(ttxReq)) else $error("output moved without tick"); // R10

  AST_REQ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    ttxReq |-> status.lineOk) else $error("request on disabled line"); // R2

endmodule

// File: rtl/ttx_req_window.sv
module ttx_req_window
  import ttx_req_pkg::*;
#(
  parameter int               LINE_W     = 10,
  parameter int               MASK_BASE  = 7,
  parameter logic [PIX_W-1:0] WIN_EURO   = 11'd360,
  parameter logic [PIX_W-1:0] WIN_NABTS  = 11'd288,
  parameter logic [PIX_W-1:0] WIN_WST    = 11'd296,
  parameter logic [PIX_W-1:0] DEF_HSTART = 11'd48,
  parameter logic [DIV_W-1:0] DEF_DIV    = 6'd4,
  parameter logic [CNT_W-1:0] DEF_CNT    = 9'd45
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapNtsc,
  input  logic              pixEn,
  input  logic              lineStrobe,
  input  logic              fieldSync,
  input  logic              fieldOdd,
  input  logic              cfgLoad,
  input  logic              cfgSysM,
  input  logic              cfgProtoOld,
  input  logic              cfgStd60,
  input  logic [REG_W-1:0]  cfgOddFirst,
  input  logic [REG_W-1:0]  cfgOddLast,
  input  logic [REG_W-1:0]  cfgEvenFirst,
  input  logic [REG_W-1:0]  cfgEvenLast,
  input  logic [MASK_W-1:0] cfgMaskOdd,
  input  logic [MASK_W-1:0] cfgMaskEven,
  input  logic [PIX_W-1:0]  cfgHStart,
  input  logic [DIV_W-1:0]  cfgBitDiv,
  input  logic [CNT_W-1:0]  cfgBitCount,
  output logic              ttxReq
);

  ttxCfg_t    cfgIn;
  ttxStrobe_t strobe;
  ttxStatus_t status;
  logic       lineStart;

  assign lineStart = pixEn && (lineStrobe || fieldSync);

  always_comb begin
    cfgIn.sysM      = cfgSysM;
    cfgIn.protoOld  = cfgProtoOld;
    cfgIn.std60     = cfgStd60;
    cfgIn.oddFirst  = cfgOddFirst;
    cfgIn.oddLast   = cfgOddLast;
    cfgIn.evenFirst = cfgEvenFirst;
    cfgIn.evenLast  = cfgEvenLast;
    cfgIn.maskOdd   = cfgMaskOdd;
    cfgIn.maskEven  = cfgMaskEven;
    cfgIn.hStart    = cfgHStart;
    cfgIn.bitDiv    = cfgBitDiv;
    cfgIn.bitCount  = cfgBitCount;
  end

  ttx_req_dp #(
    .LINE_W(LINE_W), .MASK_BASE(MASK_BASE),
    .WIN_EURO(WIN_EURO), .WIN_NABTS(WIN_NABTS), .WIN_WST(WIN_WST),
    .DEF_HSTART(DEF_HSTART), .DEF_DIV(DEF_DIV), .DEF_CNT(DEF_CNT)
  ) dp (
    .clk(clk), .rstN(rstN), .strapNtsc(strapNtsc), .pixEn(pixEn),
    .lineStart(lineStart), .fieldSync(fieldSync), .fieldOdd(fieldOdd),
    .cfgLoad(cfgLoad), .cfgIn(cfgIn), .strobe(strobe), .status(status)
  );

  ttx_req_ctl ctl (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .lineStart(lineStart),
    .status(status), .strobe(strobe), .ttxReq(ttxReq)
  );

endmodule

// File: tb/ttx_req_window_test.sv
`timescale 1ns/1ps
module ttx_req_window_test;

  localparam int T_EURO = 20, T_NABTS = 14, T_WST = 17, T_BASE = 7;

  typedef struct {
    int sysM, old, std60, oS, oE, eS, eE, mO, mE, hS, bd, bc;
  } mcfg_t;

  logic clk = 1'b0;
  logic rstN = 1'b0, strapNtsc = 1'b0, pixEn = 1'b0, lineStrobe = 1'b0;
  logic fieldSync = 1'b0, fieldOdd = 1'b0, cfgLoad = 1'b0;
  logic cfgSysM = 1'b0, cfgProtoOld = 1'b0, cfgStd60 = 1'b0;
  logic [7:0]  cfgOddFirst = '0, cfgOddLast = '0, cfgEvenFirst = '0, cfgEvenLast = '0;
  logic [15:0] cfgMaskOdd = '0, cfgMaskEven = '0;
  logic [10:0] cfgHStart = '0;
  logic [5:0]  cfgBitDiv = '0;
  logic [8:0]  cfgBitCount = '0;
  logic        ttxReq;

  always #4 clk = ~clk;

  ttx_req_window #(
    .WIN_EURO(11'd20), .WIN_NABTS(11'd14), .WIN_WST(11'd17),
    .DEF_HSTART(11'd4), .DEF_DIV(6'd3), .DEF_CNT(9'd5)
  ) uut (
    .clk(clk), .rstN(rstN), .strapNtsc(strapNtsc), .pixEn(pixEn),
    .lineStrobe(lineStrobe), .fieldSync(fieldSync), .fieldOdd(fieldOdd),
    .cfgLoad(cfgLoad), .cfgSysM(cfgSysM), .cfgProtoOld(cfgProtoOld),
    .cfgStd60(cfgStd60), .cfgOddFirst(cfgOddFirst), .cfgOddLast(cfgOddLast),
    .cfgEvenFirst(cfgEvenFirst), .cfgEvenLast(cfgEvenLast),
    .cfgMaskOdd(cfgMaskOdd), .cfgMaskEven(cfgMaskEven), .cfgHStart(cfgHStart),
    .cfgBitDiv(cfgBitDiv), .cfgBitCount(cfgBitCount), .ttxReq(ttxReq)
  );

  int vectors = 0, fails = 0, cycles = 0;
  bit running = 0, gapMode = 0;
  string scen = "R4";

  // behavioural reference state
  mcfg_t mPend, mAct;
  int    mLine = 0, mPar = 0, mTick = 0;
  bit    mOk = 0, expReq = 0;
  string expTag = "R4", lineTag = "R2";

  function automatic mcfg_t defaults(bit ntsc);
    mcfg_t c;
    c.sysM = ntsc; c.old = 0; c.std60 = 0;
    c.oS = ntsc ? 5 : 4;  c.eS = c.oS;
    c.oE = ntsc ? 16 : 22; c.eE = c.oE;
    c.mO = 0; c.mE = 0; c.hS = 4; c.bd = 3; c.bc = 5;
    return c;
  endfunction

  function automatic bit inWindow(mcfg_t c, int par, int L);
    int s, e;
    s = (par != 0) ? c.oS : c.eS;
    e = (par != 0) ? c.oE : c.eE;
    if (c.sysM != 0) return (L >= s + 4) && (L <= e + 3);
    return (L >= s + 1) && (L <= e);
  endfunction

  function automatic bit isMasked(mcfg_t c, int par, int L);
    int pal, idx, m;
    pal = (c.sysM != 0) ? L - 3 : L;
    idx = pal - T_BASE;
    m = (par != 0) ? c.mO : c.mE;
    if (idx < 0 || idx > 15) return 0;
    return ((m >> idx) & 1) == 1;
  endfunction

  function automatic bit reqAt(mcfg_t c, bit ok, int m);
    int m0, len, d, k;
    if (!ok || m < 1) return 0;
    m0 = c.hS + 1;
    if (c.old != 0) begin
      len = (c.sysM == 0) ? T_EURO : ((c.std60 != 0) ? T_WST : T_NABTS);
      return (m >= m0) && (m < m0 + len);
    end
    d = (c.bd < 2) ? 2 : c.bd;
    if (c.bc == 0 || m < m0) return 0;
    k = m - m0;
    return (k % d == 0) && (k / d < c.bc);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPend = defaults(strapNtsc); mAct = mPend;
      mLine = 0; mPar = 0; mTick = 0; mOk = 0; expReq = 0; expTag = "R4";
    end else begin
      if (pixEn) begin
        if (fieldSync) begin
          mAct = mPend; mLine = 0; mPar = fieldOdd; mOk = 0; mTick = 0;
          expReq = 0; expTag = "R1";
        end else if (lineStrobe) begin
          mLine++;
          mOk = inWindow(mAct, mPar, mLine) && !isMasked(mAct, mPar, mLine);
          if (mOk) lineTag = (mAct.old != 0) ? ((mAct.sysM != 0) ? "R8" : "R7") : "R6";
          else if (inWindow(mAct, mPar, mLine)) lineTag = "R5";
          else lineTag = (mAct.sysM != 0) ? "R3" : "R2";
          mTick = 0; expReq = 0; expTag = "R11";
        end else begin
          mTick++;
          expReq = reqAt(mAct, mOk, mTick);
          expTag = lineTag;
        end
      end else begin
        expTag = "R10";
      end
      if (cfgLoad) begin
        mPend.sysM = cfgSysM; mPend.old = cfgProtoOld; mPend.std60 = cfgStd60;
        mPend.oS = cfgOddFirst; mPend.oE = cfgOddLast;
        mPend.eS = cfgEvenFirst; mPend.eE = cfgEvenLast;
        mPend.mO = cfgMaskOdd; mPend.mE = cfgMaskEven; mPend.hS = cfgHStart;
        mPend.bd = cfgBitDiv; mPend.bc = cfgBitCount;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && running) begin
      vectors++;
      if (ttxReq !== expReq) begin
        fails++;
        $display("FAIL %s/%s: ttxReq got %0b exp %0b (line %0d tick %0d)",
                 scen, expTag, ttxReq, expReq, mLine, mTick);
      end
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog (all requirements): got hang exp completion");
      summary();
      $finish;
    end
  end

  task automatic tick(bit ls, bit fs, bit odd);
    if (gapMode) begin
      @(negedge clk);
      pixEn = 1'b0; lineStrobe = ls; fieldSync = fs; fieldOdd = ~odd; cfgLoad = 1'b0;
    end
    @(negedge clk);
    pixEn = 1'b1; lineStrobe = ls; fieldSync = fs; fieldOdd = odd; cfgLoad = 1'b0;
  endtask

  task automatic loadCfg(mcfg_t c);
    @(negedge clk);
    pixEn = 1'b0; lineStrobe = 1'b0; fieldSync = 1'b0; cfgLoad = 1'b1;
    cfgSysM = c.sysM[0]; cfgProtoOld = c.old[0]; cfgStd60 = c.std60[0];
    cfgOddFirst = 8'(c.oS); cfgOddLast = 8'(c.oE);
    cfgEvenFirst = 8'(c.eS); cfgEvenLast = 8'(c.eE);
    cfgMaskOdd = 16'(c.mO); cfgMaskEven = 16'(c.mE);
    cfgHStart = 11'(c.hS); cfgBitDiv = 6'(c.bd); cfgBitCount = 9'(c.bc);
  endtask

  task automatic runField(bit odd, int nLines, int len, int loadAt, mcfg_t late);
    tick(1'b0, 1'b1, odd);
    for (int t = 1; t < len; t++) tick(1'b0, 1'b0, odd);
    for (int l = 1; l <= nLines; l++) begin
      if (l == loadAt) loadCfg(late);
      tick(1'b1, 1'b0, odd);
      for (int t = 1; t < len; t++) tick(1'b0, 1'b0, odd);
    end
  endtask

  task automatic twoFields(mcfg_t c, int nLines, int len);
    loadCfg(c);
    runField(1'b1, nLines, len, -1, c);
    runField(1'b0, nLines, len, -1, c);
  endtask

  initial begin
    mcfg_t c, b;
    repeat (3) @(negedge clk);
    vectors++;
    if (ttxReq !== 1'b0) begin
      fails++;
      $display("FAIL R4: reset ttxReq got %0b exp 0", ttxReq);
    end
    rstN = 1'b1; running = 1;

    scen = "R4";   // PAL strap defaults, no load
    runField(1'b0, 26, 40, -1, defaults(0));
    runField(1'b1, 26, 40, -1, defaults(0));

    scen = "R2";
    c = defaults(0); c.oS = 6; c.oE = 9; c.eS = 10; c.eE = 14;
    c.hS = 3; c.bd = 4; c.bc = 6;
    twoFields(c, 18, 40);

    scen = "R5";   // odd line 8, even line 12; even line 7 bit lies outside the window
    c.mO = 32'h0002; c.mE = 32'h0021;
    twoFields(c, 18, 40);

    scen = "R3";   // M-system offsets; odd mask bit 0 removes line 10
    c = defaults(0); c.sysM = 1; c.oS = 2; c.oE = 8; c.eS = 5; c.eE = 10;
    c.mO = 32'h0001; c.hS = 0; c.bd = 5; c.bc = 4;
    twoFields(c, 16, 40);

    scen = "R6";   // period below 2 clamps to 2, then zero pulses
    c = defaults(0); c.bd = 1; c.bc = 7; c.hS = 6;
    twoFields(c, 24, 40);
    c.bc = 0;
    twoFields(c, 24, 40);

    scen = "R7";
    c = defaults(0); c.old = 1; c.hS = 2;
    twoFields(c, 24, 40);

    scen = "R8";
    c.sysM = 1; c.std60 = 0;
    twoFields(c, 22, 40);
    c.std60 = 1;
    twoFields(c, 22, 40);

    scen = "R11";  // window longer than the line
    c = defaults(0); c.old = 1; c.hS = 10;
    twoFields(c, 24, 18);
    c.old = 0; c.hS = 12; c.bd = 2; c.bc = 9;
    twoFields(c, 24, 18);

    scen = "R10";  // idle cycles carrying stray strobes between ticks
    gapMode = 1;
    c = defaults(0); c.hS = 2; c.bd = 3; c.bc = 4;
    twoFields(c, 24, 30);
    gapMode = 0;

    scen = "R9";   // mid-field write must wait for the next field
    c = defaults(0); c.oS = 3; c.oE = 12;
    b = c; b.oS = 9; b.oE = 15; b.old = 1; b.hS = 1;
    loadCfg(c);
    runField(1'b1, 18, 40, 4, b);
    runField(1'b1, 18, 40, -1, b);

    scen = "R1";   // parity taken at sync; parity-specific windows
    c = defaults(0); c.oS = 2; c.oE = 4; c.eS = 12; c.eE = 15;
    loadCfg(c);
    runField(1'b0, 18, 30, -1, c);
    runField(1'b1, 18, 30, -1, c);
    runField(1'b1, 18, 30, -1, c);

    scen = "R4";   // NTSC strap defaults after a fresh reset
    running = 0;
    @(negedge clk);
    rstN = 1'b0; strapNtsc = 1'b1; pixEn = 1'b0; lineStrobe = 1'b0; fieldSync = 1'b0;
    repeat (3) @(negedge clk);
    vectors++;
    if (ttxReq !== 1'b0) begin
      fails++;
      $display("FAIL R4: reset ttxReq got %0b exp 0", ttxReq);
    end
    rstN = 1'b1; running = 1;
    runField(1'b0, 24, 40, -1, defaults(1));
    runField(1'b1, 24, 40, -1, defaults(1));

    @(negedge clk);
    pixEn = 1'b0;
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule